// File: doc/BRIEF.md
# Shift and Rotate Unit

This is a purely combinational shift/rotate datapath for a CPU execution stage. It takes one operand and works on its low 8, 16 or 32 bits, as the size code selects. It can shift logically or arithmetically in either direction, rotate in either direction, or rotate through the carry flag. The distance is one or two bit positions. A two-position shift is produced as a single operation and is not built from chained one-position steps. A bitwise NOT is available on the same path.

Besides the result, the unit produces four condition flags: carry, overflow, negative and zero. Carry holds the last bit that left the operand. Overflow reports a sign change during an arithmetic left shift. Negative and zero describe the result at the selected width. Bits of the operand above the selected width come out unchanged, so a register-file write port can store the whole word. Write-back, and extracting the distance bit from the instruction word, belong to the surrounding pipeline.

Top module: `shrot_unit`

## Requirements
- R1: `op_i` encodes 0=logical left, 1=logical right, 2=arithmetic left, 3=arithmetic right, 4=rotate left, 5=rotate right, 6=rotate left through carry, 7=rotate right through carry, 8=NOT. `size_i` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. `dist2_i`=0 moves one position and 1 moves two positions.
- R2: Logical and arithmetic left shifts fill the vacated low bits with zero. C_out is the MSB of the operand for one position, and the bit just below the MSB for two positions.
- R3: Logical right shift fills the vacated top bits with zero. For every right shift or right rotate, C_out is operand bit 0 for one position and bit 1 for two positions.
- R4: Arithmetic right shift copies the operand's original sign bit into every vacated top position.
- R5: On arithmetic left shift, V is set when any bit shifted out of the sign position, or the bit shifted into it, differs from the final sign bit. Every other operation drives V to 0.
- R6: Plain rotates move the bits leaving one end into the other end. For rotate left, C equals result bit 0. For rotate right, C equals the result MSB.
- R7: Rotates through carry put `carry_i` into the vacated end, and the last bit rotated out becomes C. A two-position rotate behaves as a rotate of the (width+1)-bit value made of the carry and the operand.
- R8: N equals the result MSB at the selected width. Z is 1 exactly when the result bits at the selected width are all zero.
- R9: NOT inverts every bit of the selected width, drives V to 0, sets N and Z from the result, and passes `carry_i` to C.
- R10: Result bits above the selected width equal the corresponding operand bits.
- R11: Op codes 9 to 15 pass the operand through unchanged, pass `carry_i` to C, drive V to 0, and set N and Z from the operand at the selected width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (see R1) |
| size_i | input | 2 | Operand width select |
| dist2_i | input | 1 | 0 = one position, 1 = two positions |
| operand_i | input | 32 | Operand word |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Result word, upper bits passed through |
| c_o | output | 1 | Carry flag out |
| v_o | output | 1 | Overflow flag out |
| n_o | output | 1 | Negative flag out |
| z_o | output | 1 | Zero flag out |

## Verification
The unit holds no state, so a fault cannot persist between operations. Any error shows up on the result and flag outputs in the same evaluation as the input pattern that triggers it. Two kinds of fault are the ones most likely to escape notice. The first is a wrong lane select or width mask: it appears as a corrupted upper byte or a misplaced N flag, but only with a non-byte size or a non-zero upper operand. The second is a swapped carry tap: it appears only in C, and only for the two-position case. For this reason the directed scenarios pair each distance with each width, and a pseudo-random sweep covers every code, including the unused ones.

// File: rtl/shr_pkg.sv
package shr_pkg;

    typedef enum logic [3:0] {
        OP_LSL  = 4'd0,
        OP_LSR  = 4'd1,
        OP_ASL  = 4'd2,
        OP_ASR  = 4'd3,
        OP_ROL  = 4'd4,
        OP_ROR  = 4'd5,
        OP_RCL  = 4'd6,
        OP_RCR  = 4'd7,
        OP_NOT  = 4'd8
    } shr_op_e;

    typedef enum logic [1:0] {
        LANE_B = 2'd0,
        LANE_W = 2'd1,
        LANE_L = 2'd2
    } shr_lane_e;

    typedef struct packed {
        logic c;
        logic v;
        logic n;
        logic z;
    } shr_flags_t;

    // Map the size code to a lane; codes 2 and 3 both select the widest lane.
    function automatic shr_lane_e size_to_lane(input logic [1:0] size);
        case (size)
            2'd0:    return LANE_B;
            2'd1:    return LANE_W;
            default: return LANE_L;
        endcase
    endfunction

    function automatic logic is_left_shift(input shr_op_e op);
        return (op == OP_LSL) || (op == OP_ASL);
    endfunction

endpackage

// File: rtl/shr_lane.sv
module shr_lane
    import shr_pkg::*;
#(
    parameter int W = 8
) (
    input  shr_op_e        op,
    input  logic           dist2,
    input  logic [W-1:0]   x,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           c,
    output logic           v
);

    logic [W-1:0] left_r, lsr_r, asr_r, rol_r, ror_r, rcl_r, rcr_r;
    logic         left_c, right_c, rcl_c;
    logic         asl_v;

    // One- and two-position variants are each a single rewiring of x.
    always_comb begin
        if (!dist2) begin
            left_r  = {x[W-2:0], 1'b0};
            lsr_r   = {1'b0, x[W-1:1]};
            asr_r   = {x[W-1], x[W-1:1]};
            rol_r   = {x[W-2:0], x[W-1]};
            ror_r   = {x[0], x[W-1:1]};
            rcl_r   = {x[W-2:0], cin};
            rcr_r   = {cin, x[W-1:1]};
            left_c  = x[W-1];
            right_c = x[0];
            rcl_c   = x[W-1];
            asl_v   = x[W-1] ^ x[W-2];
        end else begin
            left_r  = {x[W-3:0], 2'b00};
            lsr_r   = {2'b00, x[W-1:2]};
            asr_r   = {{2{x[W-1]}}, x[W-1:2]};
            rol_r   = {x[W-3:0], x[W-1:W-2]};
            ror_r   = {x[1:0], x[W-1:2]};
            rcl_r   = {x[W-3:0], cin, x[W-1]};
            rcr_r   = {x[0], cin, x[W-1:2]};
            left_c  = x[W-2];
            right_c = x[1];
            rcl_c   = x[W-2];
            asl_v   = (x[W-1] ^ x[W-3]) | (x[W-2] ^ x[W-3]);
        end
    end

    always_comb begin
        res = x;
        c   = cin;
        v   = 1'b0;
        case (op)
            OP_LSL: begin res = left_r; c = left_c;              end
            OP_ASL: begin res = left_r; c = left_c; v = asl_v;   end
            OP_LSR: begin res = lsr_r;  c = right_c;             end
            OP_ASR: begin res = asr_r;  c = right_c;             end
            OP_ROL: begin res = rol_r;  c = left_c;              end
            OP_ROR: begin res = ror_r;  c = right_c;             end
            OP_RCL: begin res = rcl_r;  c = rcl_c;               end
            OP_RCR: begin res = rcr_r;  c = right_c;             end
            OP_NOT: begin res = ~x;                              end
            default: ;
        endcase
    end

    always_comb begin
        if (op != OP_ASL) begin
            AST_V_ONLY_ASL: assert (v == 1'b0) else $error("V set outside ASL"); // R5
        end
        if (op == OP_LSR) begin
            AST_LSR_TOP_ZERO: assert (res[W-1] == 1'b0) else $error("LSR top bit"); // R3
        end
        if (op == OP_ASR) begin
            AST_ASR_SIGN: assert (res[W-1] == x[W-1]) else $error("ASR sign"); // R4
        end
        if (op == OP_ROL) begin
            AST_ROL_CARRY: assert (c == res[0]) else $error("ROL carry"); // R6
        end
        if (op == OP_ROR) begin
            AST_ROR_CARRY: assert (c == res[W-1]) else $error("ROR carry"); // R6
        end
        if (op == OP_NOT) begin
            AST_NOT_CARRY: assert (c == cin) else $error("NOT carry"); // R9
        end
        if (is_left_shift(op)) begin
            AST_LEFT_LSB_ZERO: assert (res[0] == 1'b0) else $error("left fill"); // R2
        end
    end

endmodule

// File: rtl/shr_flags.sv
module shr_flags
    import shr_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int BASE_W    = 8,
    parameter int NUM_LANES = 3
) (
    input  logic [DATA_W-1:0] res_lane,
    input  shr_lane_e         lane_sel,
    input  logic              c_in,
    input  logic              v_in,
    output shr_flags_t        flags
);

    always_comb begin
        flags.c = c_in;
        flags.v = v_in;
        flags.n = 1'b0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (lane_sel == shr_lane_e'(i))
                flags.n = res_lane[(BASE_W << i) - 1];
        end
        // res_lane is zero above the selected width.
        flags.z = (res_lane == '0);
    end

endmodule

// File: rtl/shr_merge.sv
module shr_merge #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] lane_res,
    input  logic [DATA_W-1:0] lane_mask,
    output logic [DATA_W-1:0] result
);

    always_comb begin
        result = (operand & ~lane_mask) | (lane_res & lane_mask);
    end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BASE_W = 8
) (
    input  logic [3:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic              dist2_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] result_o,
    output logic              c_o,
    output logic              v_o,
    output logic              n_o,
    output logic              z_o
);

    localparam int NUM_LANES = 3;
    typedef logic [DATA_W-1:0] word_t;

    shr_op_e    op;
    shr_lane_e  lane_sel;
    word_t      lane_res  [NUM_LANES];
    word_t      lane_mask [NUM_LANES];
    logic       lane_c    [NUM_LANES];
    logic       lane_v    [NUM_LANES];
    word_t      sel_res, sel_mask;
    logic       sel_c, sel_v;
    shr_flags_t flags;

    assign op       = shr_op_e'(op_i);
    assign lane_sel = size_to_lane(size_i);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LW = BASE_W << g;
        logic [LW-1:0] lr;
        shr_lane #(.W(LW)) u_lane (
            .op    (op),
            .dist2 (dist2_i),
            .x     (operand_i[LW-1:0]),
            .cin   (carry_i),
            .res   (lr),
            .c     (lane_c[g]),
            .v     (lane_v[g])
        );
        assign lane_res[g]  = word_t'(lr);
        assign lane_mask[g] = word_t'({LW{1'b1}});
    end

    always_comb begin
        sel_res  = lane_res[0];
        sel_mask = lane_mask[0];
        sel_c    = lane_c[0];
        sel_v    = lane_v[0];
        for (int i = 1; i < NUM_LANES; i++) begin
            if (lane_sel == shr_lane_e'(i)) begin
                sel_res  = lane_res[i];
                sel_mask = lane_mask[i];
                sel_c    = lane_c[i];
                sel_v    = lane_v[i];
            end
        end
    end

    shr_flags #(.DATA_W(DATA_W), .BASE_W(BASE_W), .NUM_LANES(NUM_LANES)) u_flags (
        .res_lane (sel_res),
        .lane_sel (lane_sel),
        .c_in     (sel_c),
        .v_in     (sel_v),
        .flags    (flags)
    );

    shr_merge #(.DATA_W(DATA_W)) u_merge (
        .operand   (operand_i),
        .lane_res  (sel_res),
        .lane_mask (sel_mask),
        .result    (result_o)
    );

    assign c_o = flags.c;
    assign v_o = flags.v;
    assign n_o = flags.n;
    assign z_o = flags.z;

    always_comb begin
        if (lane_sel == LANE_B) begin
            AST_UPPER_KEEP: assert (result_o[DATA_W-1:BASE_W] == operand_i[DATA_W-1:BASE_W])
                else $error("upper bits altered"); // R10
        end
        AST_Z_MATCH: assert (z_o == ((result_o & sel_mask) == '0)) else $error("Z flag"); // R8
        if (op_i > 4'd8) begin
            AST_UNDEF_PASS: assert (result_o == operand_i && c_o == carry_i) else $error("undef op"); // R11
        end
    end

endmodule

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;

    logic        clk = 1'b0;
    logic [3:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic        dist2_i = 1'b0;
    logic [31:0] operand_i = '0;
    logic        carry_i = 1'b0;
    logic [31:0] result_o;
    logic        c_o, v_o, n_o, z_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    shrot_unit u_dut (
        .op_i(op_i), .size_i(size_i), .dist2_i(dist2_i), .operand_i(operand_i),
        .carry_i(carry_i), .result_o(result_o), .c_o(c_o), .v_o(v_o), .n_o(n_o), .z_o(z_o)
    );

    // Independent model: repeated one-position steps over an explicit width.
    function automatic logic [35:0] model(input logic [3:0] op, input logic [1:0] sz,
                                          input logic d2, input logic [31:0] x, input logic ci);
        int w;
        int steps;
        logic [31:0] m, a;
        logic c, v, msb, lsb;
        w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        a = x & m;
        c = ci;
        v = 1'b0;
        steps = d2 ? 2 : 1;
        if (op <= 4'd7) begin
            for (int s = 0; s < steps; s++) begin
                msb = a[w-1];
                lsb = a[0];
                case (op)
                    4'd0, 4'd2: begin
                        c = msb; a = (a << 1) & m;
                        if (op == 4'd2 && a[w-1] != msb) v = 1'b1;
                    end
                    4'd1: begin c = lsb; a = a >> 1; end
                    4'd3: begin c = lsb; a = (a >> 1) | ({31'd0, msb} << (w-1)); end
                    4'd4: begin c = msb; a = ((a << 1) | {31'd0, msb}) & m; end
                    4'd5: begin c = lsb; a = (a >> 1) | ({31'd0, lsb} << (w-1)); end
                    4'd6: begin a = ((a << 1) | {31'd0, c}) & m; c = msb; end
                    default: begin a = (a >> 1) | ({31'd0, c} << (w-1)); c = lsb; end
                endcase
            end
        end else if (op == 4'd8) begin
            a = ~a & m;
        end
        return {(x & ~m) | a, c, v, a[w-1], a == 32'd0};
    endfunction

    task automatic apply_check(input logic [3:0] op, input logic [1:0] sz, input logic d2,
                               input logic [31:0] x, input logic ci, input string tag);
        logic [35:0] exp, act;
        @(posedge clk);
        op_i = op; size_i = sz; dist2_i = d2; operand_i = x; carry_i = ci;
        @(negedge clk);
        exp = model(op, sz, d2, x, ci);
        act = {result_o, c_o, v_o, n_o, z_o};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s op=%0d sz=%0d d2=%0b x=%h ci=%0b actual res=%h cvnz=%b expected res=%h cvnz=%b",
                     tag, op, sz, d2, x, ci, act[35:4], act[3:0], exp[35:4], exp[3:0]);
        end
    endtask

    task automatic t_idle_zero;
        apply_check(4'd0, 2'd0, 1'b0, 32'h0, 1'b0, "R8 idle zero");
        apply_check(4'd1, 2'd2, 1'b1, 32'h0, 1'b1, "R8 zero long");
    endtask

    task automatic t_left;
        apply_check(4'd0, 2'd0, 1'b0, 32'h0000_0081, 1'b0, "R2 lsl b 1");
        apply_check(4'd0, 2'd0, 1'b1, 32'h0000_0041, 1'b0, "R2 lsl b 2");
        apply_check(4'd0, 2'd1, 1'b1, 32'h0000_8001, 1'b1, "R2 lsl w 2");
        apply_check(4'd0, 2'd2, 1'b0, 32'h8000_0001, 1'b0, "R2 lsl l 1");
    endtask

    task automatic t_right;
        apply_check(4'd1, 2'd0, 1'b0, 32'h0000_0081, 1'b0, "R3 lsr b 1");
        apply_check(4'd1, 2'd1, 1'b1, 32'h0000_8002, 1'b0, "R3 lsr w 2");
        apply_check(4'd1, 2'd2, 1'b1, 32'hFFFF_FFFD, 1'b1, "R3 lsr l 2");
    endtask

    task automatic t_asr;
        apply_check(4'd3, 2'd0, 1'b0, 32'h0000_0081, 1'b0, "R4 asr b 1");
        apply_check(4'd3, 2'd0, 1'b1, 32'h0000_0082, 1'b0, "R4 asr b 2");
        apply_check(4'd3, 2'd2, 1'b1, 32'h8000_0003, 1'b0, "R4 asr l 2");
        apply_check(4'd3, 2'd1, 1'b1, 32'h0000_4001, 1'b0, "R4 asr w pos");
    endtask

    task automatic t_asl_v;
        apply_check(4'd2, 2'd0, 1'b0, 32'h0000_0040, 1'b0, "R5 asl 1 sign change");
        apply_check(4'd2, 2'd0, 1'b0, 32'h0000_00C0, 1'b0, "R5 asl 1 no change");
        apply_check(4'd2, 2'd0, 1'b1, 32'h0000_0020, 1'b0, "R5 asl 2 shifted-in differs");
        apply_check(4'd2, 2'd0, 1'b1, 32'h0000_00E0, 1'b0, "R5 asl 2 all equal");
        apply_check(4'd2, 2'd1, 1'b1, 32'h0000_8000, 1'b0, "R5 asl w 2 out differs");
        apply_check(4'd0, 2'd0, 1'b0, 32'h0000_0040, 1'b0, "R5 lsl keeps V clear");
    endtask

    task automatic t_rot;
        apply_check(4'd4, 2'd0, 1'b0, 32'h0000_0081, 1'b0, "R6 rol b 1");
        apply_check(4'd4, 2'd0, 1'b1, 32'h0000_0040, 1'b1, "R6 rol b 2");
        apply_check(4'd5, 2'd1, 1'b0, 32'h0000_0001, 1'b0, "R6 ror w 1");
        apply_check(4'd5, 2'd2, 1'b1, 32'h0000_0002, 1'b0, "R6 ror l 2");
    endtask

    task automatic t_rotc;
        apply_check(4'd6, 2'd0, 1'b0, 32'h0000_0080, 1'b1, "R7 rcl b 1");
        apply_check(4'd6, 2'd0, 1'b1, 32'h0000_0080, 1'b1, "R7 rcl b 2");
        apply_check(4'd6, 2'd2, 1'b1, 32'h4000_0000, 1'b0, "R7 rcl l 2");
        apply_check(4'd7, 2'd0, 1'b0, 32'h0000_0001, 1'b1, "R7 rcr b 1");
        apply_check(4'd7, 2'd1, 1'b1, 32'h0000_0001, 1'b1, "R7 rcr w 2");
        apply_check(4'd7, 2'd2, 1'b1, 32'h0000_0002, 1'b0, "R7 rcr l 2");
    endtask

    task automatic t_not;
        apply_check(4'd8, 2'd0, 1'b0, 32'h1234_56FF, 1'b1, "R9 not b to zero");
        apply_check(4'd8, 2'd1, 1'b0, 32'h0000_0000, 1'b0, "R9 not w negative");
        apply_check(4'd8, 2'd2, 1'b1, 32'h8000_0000, 1'b0, "R9 not l");
    endtask

    task automatic t_upper;
        apply_check(4'd1, 2'd0, 1'b1, 32'hDEAD_BE80, 1'b0, "R10 byte upper keep");
        apply_check(4'd6, 2'd1, 1'b0, 32'hCAFE_8000, 1'b1, "R10 word upper keep");
        apply_check(4'd0, 2'd3, 1'b0, 32'h8000_0000, 1'b0, "R1 size 3 is long");
    endtask

    task automatic t_undef;
        apply_check(4'd9,  2'd0, 1'b1, 32'hAB00_0080, 1'b1, "R11 undef 9");
        apply_check(4'd15, 2'd2, 1'b0, 32'h0000_0000, 1'b0, "R11 undef 15");
    endtask

    task automatic t_sweep;
        logic [31:0] s;
        s = 32'h1357_9BDF;
        for (int i = 0; i < 400; i++) begin
            s = s ^ (s << 13);
            s = s ^ (s >> 17);
            s = s ^ (s << 5);
            apply_check(s[3:0], s[5:4], s[6], s ^ {s[15:0], s[31:16]}, s[7], "R1 sweep");
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        t_idle_zero();
        t_left();
        t_right();
        t_asr();
        t_asl_v();
        t_rot();
        t_rotc();
        t_not();
        t_upper();
        t_undef();
        t_sweep();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule